// File: doc/BRIEF.md
# Interleaved Dot-Product Accumulator

This processing element takes one vector of signed feature values and one vector of signed weight values every clock. It multiplies them lane by lane and sums the products in a fully pipelined tree. The result is then added to a running partial sum. The partial sums live in a ring of registers that is exactly as deep as the dot-product pipeline. As a result, `LAT` separate output computations share one datapath in strict rotation. Each input cycle belongs to the slot of its position modulo `LAT`, and nothing ever stalls.

Two flags travel down the pipeline with each vector. A start flag makes that contribution the first term of a new output, so the old partial sum of the slot is discarded. A last flag closes the output: the finished sum is presented with a one-cycle strobe, and the slot is cleared. The feature vector is also passed on, one clock later, to the next element of a daisy chain. This lets a row of such elements share one feature stream.

Top module: `dpa_unit`

## Requirements
- R1: The dot product is the sum over lanes i of feat_i[i*DW +: DW] times wgt_i[i*DW +: DW]. Both operands are two's-complement signed. The sum is sign-extended to AW bits before it is accumulated.
- R2: When start_i is high, the contribution ignores whatever the slot held before. The result is the dot product of that cycle alone, plus any later terms.
- R3: When start_i is low, the contribution is added to the partial sum written LAT cycles earlier, in the same rotation slot.
- R4: sum_vld_o is high for exactly one clock, LAT rising edges after the edge that samples last_i high. In that clock, sum_o holds the slot's accumulated value including that last term.
- R5: After a last term the slot is cleared to zero. A following contribution to that slot with start_i low therefore begins from zero.
- R6: In every other clock sum_vld_o is low, and sum_o keeps its previous value.
- R7: A cycle with start_i and last_i both high produces an output equal to that single dot product.
- R8: LAT independent outputs of differing lengths can be interleaved, one vector per clock, with no idle cycles.
- R9: feat_fwd_o equals the feat_i value sampled at the previous rising edge.
- R10: While rst_n is low, sum_vld_o, sum_o and feat_fwd_o are zero, and every partial sum is zero. A contribution with start_i low after reset begins from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_i | input | VEC*DW | Feature lanes, lane i at bits [i*DW +: DW] |
| wgt_i | input | VEC*DW | Weight lanes, same layout as feat_i |
| start_i | input | 1 | This term opens a new output |
| last_i | input | 1 | This term closes the output |
| feat_fwd_o | output | VEC*DW | Feature lanes delayed one clock for the next element |
| sum_o | output | AW | Finished sum, signed |
| sum_vld_o | output | 1 | One-clock strobe marking a finished sum |

## Verification
Directed cycles first show that reset clears the slots. They then check that a start term drops junk already accumulated in its slot, and that a last term clears the slot so the next unflagged term starts at zero. A single-term output, and lanes holding the most negative value, test sign handling and the width of the sum. A long run of random-length streams then keeps all LAT slots busy at once. Any mix-up of slots, or a ring depth that differs from the pipeline depth, would show up as sums leaking between streams. A missing or extra strobe is caught by checking sum_vld_o every clock.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   // flags carried beside each vector down the pipeline
   typedef struct packed {
      logic start;
      logic last;
   } dpa_tag_t;

   // stages used by the multiply stage plus one register per tree level
   function automatic int tree_stages(input int vec);
      return 1 + $clog2(vec);
   endfunction

endpackage

// File: rtl/dpa_dot.sv
module dpa_dot
   import dpa_pkg::*;
#(
   parameter int VEC = 8,
   parameter int DW  = 8,
   parameter int LAT = 4,
   localparam int LV = $clog2(VEC),
   localparam int SW = 2 * DW + LV
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [VEC*DW-1:0]     feat_i,
   input  logic [VEC*DW-1:0]     wgt_i,
   input  dpa_tag_t              tag_i,
   output logic signed [SW-1:0]  dp_o,
   output dpa_tag_t              tag_o
);
   localparam int PAD  = LAT - tree_stages(VEC);
   localparam int HALF = VEC / 2;

   function automatic logic signed [SW-1:0] sx(input logic [DW-1:0] v);
      return SW'($signed(v));
   endfunction

   // node[0] holds products, node[l] holds level-l partial sums
   logic signed [SW-1:0] node [0:LV][0:VEC-1];
   dpa_tag_t             tagp [0:LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l <= LV; l++)
            for (int i = 0; i < VEC; i++)
               node[l][i] <= '0;
      end else begin
         for (int i = 0; i < VEC; i++)
            node[0][i] <= sx(feat_i[i*DW +: DW]) * sx(wgt_i[i*DW +: DW]);
         for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < HALF; i++) begin
               if (i < (VEC >> (l + 1)))
                  node[l+1][i] <= node[l][2*i] + node[l][2*i+1];
               else
                  node[l+1][i] <= '0;
            end
            for (int i = HALF; i < VEC; i++)
               node[l+1][i] <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++)
            tagp[k] <= '0;
      end else begin
         tagp[0] <= tag_i;
         for (int k = 1; k < LAT; k++)
            tagp[k] <= tagp[k-1];
      end
   end

   assign tag_o = tagp[LAT-1];

   generate
      if (PAD > 0) begin : g_pad
         logic signed [SW-1:0] padr [0:PAD-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < PAD; k++)
                  padr[k] <= '0;
            end else begin
               padr[0] <= node[LV][0];
               for (int k = 1; k < PAD; k++)
                  padr[k] <= padr[k-1];
            end
         end
         assign dp_o = padr[PAD-1];
      end else begin : g_nopad
         assign dp_o = node[LV][0];
      end
   endgenerate

endmodule

// File: rtl/dpa_ring.sv
module dpa_ring
   import dpa_pkg::*;
#(
   parameter int LAT = 4,
   parameter int SW  = 19,
   parameter int AW  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [SW-1:0]  dp_i,
   input  dpa_tag_t              tag_i,
   output logic [AW-1:0]         sum_o,
   output logic                  sum_vld_o
);
   // one partial sum per rotation slot; the tail is the slot now arriving
   logic signed [AW-1:0] sr [0:LAT-1];
   logic signed [AW-1:0] init_v;
   logic signed [AW-1:0] total;

   always_comb begin
      init_v = tag_i.start ? '0 : sr[LAT-1];
      total  = init_v + AW'(dp_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++)
            sr[k] <= '0;
         sum_o     <= '0;
         sum_vld_o <= 1'b0;
      end else begin
         sr[0] <= tag_i.last ? '0 : total;
         for (int k = 1; k < LAT; k++)
            sr[k] <= sr[k-1];
         if (tag_i.last)
            sum_o <= total;
         sum_vld_o <= tag_i.last;
      end
   end

endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
   import dpa_pkg::*;
#(
   parameter int VEC = 8,
   parameter int DW  = 8,
   parameter int LAT = 4,
   parameter int AW  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VEC*DW-1:0] feat_i,
   input  logic [VEC*DW-1:0] wgt_i,
   input  logic              start_i,
   input  logic              last_i,
   output logic [VEC*DW-1:0] feat_fwd_o,
   output logic [AW-1:0]     sum_o,
   output logic              sum_vld_o
);
   localparam int LV = $clog2(VEC);
   localparam int SW = 2 * DW + LV;

   if (VEC < 2 || (1 << LV) != VEC) begin : g_bad_vec
      $error("dpa_unit: VEC must be a power of two, at least 2");
   end
   if (LAT < tree_stages(VEC)) begin : g_bad_lat
      $error("dpa_unit: LAT shorter than the product tree");
   end
   if (AW < SW) begin : g_bad_aw
      $error("dpa_unit: AW narrower than one dot product");
   end

   dpa_tag_t             tag_in;
   dpa_tag_t             tag_dp;
   logic signed [SW-1:0] dp;

   assign tag_in.start = start_i;
   assign tag_in.last  = last_i;

   dpa_dot #(.VEC(VEC), .DW(DW), .LAT(LAT)) u_dot (
      .clk    (clk),
      .rst_n  (rst_n),
      .feat_i (feat_i),
      .wgt_i  (wgt_i),
      .tag_i  (tag_in),
      .dp_o   (dp),
      .tag_o  (tag_dp)
   );

   dpa_ring #(.LAT(LAT), .SW(SW), .AW(AW)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp_i      (dp),
      .tag_i     (tag_dp),
      .sum_o     (sum_o),
      .sum_vld_o (sum_vld_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) feat_fwd_o <= '0;
      else        feat_fwd_o <= feat_i;
   end

endmodule

// File: rtl/dpa_unit_chk.sv
module dpa_unit_chk #(
   parameter int VEC = 8,
   parameter int DW  = 8,
   parameter int LAT = 4,
   parameter int AW  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VEC*DW-1:0] feat_i,
   input logic [VEC*DW-1:0] wgt_i,
   input logic              start_i,
   input logic              last_i,
   input logic [VEC*DW-1:0] feat_fwd_o,
   input logic [AW-1:0]     sum_o,
   input logic              sum_vld_o
);
   function automatic logic [AW-1:0] dotf(input logic [VEC*DW-1:0] a,
                                          input logic [VEC*DW-1:0] b);
      logic signed [AW-1:0] acc;
      acc = '0;
      for (int i = 0; i < VEC; i++)
         acc = acc + AW'($signed(a[i*DW +: DW])) * AW'($signed(b[i*DW +: DW]));
      return acc;
   endfunction

   logic          dl_last   [0:LAT];
   logic          dl_single [0:LAT];
   logic [AW-1:0] dl_dot    [0:LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k <= LAT; k++) begin
            dl_last[k]   <= 1'b0;
            dl_single[k] <= 1'b0;
            dl_dot[k]    <= '0;
         end
      end else begin
         dl_last[0]   <= last_i;
         dl_single[0] <= last_i && start_i;
         dl_dot[0]    <= dotf(feat_i, wgt_i);
         for (int k = 1; k <= LAT; k++) begin
            dl_last[k]   <= dl_last[k-1];
            dl_single[k] <= dl_single[k-1];
            dl_dot[k]    <= dl_dot[k-1];
         end
      end
   end

   assert_strobe_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sum_vld_o == dl_last[LAT]);

   assert_sum_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_vld_o |-> $stable(sum_o));

   assert_single_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dl_single[LAT] |-> sum_o == dl_dot[LAT]);

   assert_chain_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> feat_fwd_o == $past(feat_i));

endmodule

bind dpa_unit dpa_unit_chk #(.VEC(VEC), .DW(DW), .LAT(LAT), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .feat_i     (feat_i),
   .wgt_i      (wgt_i),
   .start_i    (start_i),
   .last_i     (last_i),
   .feat_fwd_o (feat_fwd_o),
   .sum_o      (sum_o),
   .sum_vld_o  (sum_vld_o)
);

// File: tb/dpa_unit_tb.sv
module dpa_unit_tb;
   localparam int VEC = 8;
   localparam int DW  = 8;
   localparam int LAT = 4;
   localparam int AW  = 32;
   localparam int RING = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [VEC*DW-1:0] feat_i = '0;
   logic [VEC*DW-1:0] wgt_i = '0;
   logic              start_i = 1'b0;
   logic              last_i = 1'b0;
   logic [VEC*DW-1:0] feat_fwd_o;
   logic [AW-1:0]     sum_o;
   logic              sum_vld_o;

   always #5 clk = ~clk;

   dpa_unit #(.VEC(VEC), .DW(DW), .LAT(LAT), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .feat_i(feat_i), .wgt_i(wgt_i),
      .start_i(start_i), .last_i(last_i), .feat_fwd_o(feat_fwd_o),
      .sum_o(sum_o), .sum_vld_o(sum_vld_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   int cyc = 0;
   int df [VEC];
   int dw [VEC];
   int acc_m [LAT];
   bit exp_v [RING];
   int exp_s [RING];
   string exp_t [RING];
   logic [VEC*DW-1:0] prev_feat = '0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int dotm();
      int s = 0;
      for (int i = 0; i < VEC; i++) s += df[i] * dw[i];
      return s;
   endfunction

   // one clock: check what the last edge produced, then drive the next term
   task automatic step(input bit st, input bit ls, input string tg);
      int slot;
      int v;
      int ix;
      @(negedge clk);
      ix = cyc % RING;
      check(sum_vld_o == exp_v[ix], exp_v[ix] ? "R4" : "R6", sum_vld_o, exp_v[ix]);
      if (exp_v[ix])
         check($signed(sum_o) == exp_s[ix], exp_t[ix], $signed(sum_o), exp_s[ix]);
      check(feat_fwd_o == prev_feat, "R9", feat_fwd_o, prev_feat);
      exp_v[ix] = 1'b0;
      for (int i = 0; i < VEC; i++) begin
         feat_i[i*DW +: DW] = DW'(df[i]);
         wgt_i[i*DW +: DW]  = DW'(dw[i]);
      end
      start_i = st;
      last_i  = ls;
      slot = cyc % LAT;
      v = (st ? 0 : acc_m[slot]) + dotm();
      if (ls) begin
         exp_v[(cyc + LAT + 1) % RING] = 1'b1;
         exp_s[(cyc + LAT + 1) % RING] = v;
         exp_t[(cyc + LAT + 1) % RING] = tg;
         acc_m[slot] = 0;
      end else begin
         acc_m[slot] = v;
      end
      prev_feat = feat_i;
      cyc++;
   endtask

   task automatic rnd_data();
      for (int i = 0; i < VEC; i++) begin
         df[i] = int'($urandom % 256) - 128;
         dw[i] = int'($urandom % 256) - 128;
      end
   endtask

   task automatic fill(input int a, input int b);
      for (int i = 0; i < VEC; i++) begin df[i] = a; dw[i] = b; end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int rem [LAT];
      void'($urandom(32'h5EED_0042));
      for (int s = 0; s < LAT; s++) begin acc_m[s] = 0; rem[s] = 0; end
      for (int k = 0; k < RING; k++) exp_v[k] = 1'b0;

      // R10: reset dominates even with live inputs
      feat_i = '1; wgt_i = '1; start_i = 1'b1; last_i = 1'b1;
      repeat (3) @(negedge clk);
      check(sum_vld_o == 1'b0, "R10", sum_vld_o, 0);
      check(sum_o == '0, "R10", sum_o, 0);
      check(feat_fwd_o == '0, "R10", feat_fwd_o, 0);
      feat_i = '0; wgt_i = '0; start_i = 1'b0; last_i = 1'b0;
      rst_n = 1'b1;

      // R10 and R3: unflagged terms after reset accumulate from zero
      for (int s = 0; s < LAT; s++) begin fill(s + 1, 2); step(0, 0, "R10"); end
      fill(1, 1); step(0, 1, "R10");          // slot 0: 16 + 8
      fill(3, -1); step(0, 0, "R3");          // slot 1 keeps adding
      fill(7, 7); step(1, 0, "R2");           // slot 2 drops its 48
      fill(0, 0); step(0, 1, "R3");           // slot 3: 64
      fill(2, 2); step(0, 1, "R5");           // slot 0 cleared, starts at 0
      fill(-3, 5); step(0, 1, "R3");          // slot 1 closes
      fill(1, -1); step(0, 1, "R2");          // slot 2 closes without the junk
      fill(-128, -128); step(1, 1, "R7");     // slot 3 single term, largest magnitude
      fill(-128, 127); step(1, 1, "R1");      // slot 0 negative extreme
      df = '{1, -2, 3, -4, 5, -6, 7, -8};
      dw = '{8, 7, 6, 5, 4, 3, 2, 1};
      step(1, 1, "R1");                       // lane ordering
      fill(0, 0);
      step(0, 0, "R6"); step(0, 0, "R6");
      for (int k = 0; k < LAT + 2; k++) step(0, 0, "R6");

      // R8: all slots busy with random-length streams
      for (int s = 0; s < LAT; s++) begin rem[s] = 0; acc_m[s] = 0; end
      for (int k = 0; k < 3000; k++) begin
         int s;
         bit st;
         bit ls;
         s = cyc % LAT;
         st = (rem[s] == 0);
         if (st) rem[s] = 1 + int'($urandom % 7);
         rem[s]--;
         ls = (rem[s] == 0);
         rnd_data();
         step(st, ls, "R8");
      end
      fill(0, 0);
      for (int k = 0; k < LAT + 3; k++) step(0, 0, "R6");
      finish_run();
   end
endmodule